// File: doc/BRIEF.md
# Palette Lookup Pixel Pipeline with Overlay

This block is the digital front of a video output stage. On every pixel clock it captures an 8-bit colour index, a 2-bit overlay selector and three active-low controls: blanking, sync and chip select. Two clock edges later it presents a 24-bit colour code and three qualifier flags to a downstream converter.

The colour code comes from a 256-entry main palette, addressed by the index. When the selector is nonzero, it comes instead from a small 3-entry overlay palette and the index plays no part. Blanking has the highest priority and produces a blank flag with an all-zero colour code. Chip select low comes next and produces a black flag with an all-zero code. The sync-enable flag travels alongside and never alters the colour.

Both palettes are filled through a separate synchronous write port. It takes an enable, a target select, an address and a 24-bit data word.

Top module: `pal_pixel_pipe`

## Requirements
- R1: While reset is held, and before any pixel has passed, the outputs are: out_blank=1, out_black=0, out_sync_en=0, out_rgb=0.
- R2: Inputs sampled on clock edge k show at the outputs just after edge k+1. After edge k alone they have not yet reached the outputs.
- R3: With ovl_sel=0 (and blank_n=1, cs_n=1), out_rgb equals the main palette entry addressed by pix_idx. pix_idx bit 0 is the least significant address bit.
- R4: With ovl_sel values 1, 2 and 3, out_rgb equals overlay entries 0, 1 and 2 respectively. ovl_sel bit 0 is its least significant bit, and pix_idx has no effect on the output.
- R5: A sampled blank_n=0 yields out_blank=1, out_black=0 and out_rgb=0, whatever pix_idx, ovl_sel and cs_n are.
- R6: A sampled cs_n=0 with blank_n=1 yields out_black=1, out_blank=0 and out_rgb=0.
- R7: out_sync_en equals the sampled sync_n, with the same latency as the colour. sync_n has no effect on out_rgb, out_blank or out_black.
- R8: The main palette entry at wr_addr is written when wr_en=1 and wr_to_ovl=0.
- R9: When wr_en=1 and wr_to_ovl=1, wr_addr[1:0] values 1, 2 and 3 write overlay entries 0, 1 and 2. Value 0 changes no entry, and wr_addr[7:2] are ignored.
- R10: out_blank and out_black are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_idx | input | 8 | Main palette index |
| ovl_sel | input | 2 | Overlay selector, 0 selects the main palette |
| blank_n | input | 1 | Active-low blanking control |
| sync_n | input | 1 | Active-low sync control |
| cs_n | input | 1 | Active-low chip select; low forces black |
| wr_en | input | 1 | Palette write strobe |
| wr_to_ovl | input | 1 | Write target: 1 overlay palette, 0 main palette |
| wr_addr | input | 8 | Write address |
| wr_data | input | 24 | Write data |
| out_rgb | output | 24 | Colour code |
| out_blank | output | 1 | Blanking level flag |
| out_black | output | 1 | Black level flag |
| out_sync_en | output | 1 | Sync current enable |

## Verification
A corrupted palette cell appears as a wrong out_rgb. It shows only two edges after its index is presented, so the bench reads back every main and overlay entry after loading them. A stale or misrouted qualifier register shows as a flag or colour off by one pixel, or a priority slip between blank and black. The bench changes one control at a time around a steady pixel and samples exactly two edges later. It also samples one edge early to catch a shortened pipeline.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PIX_IDX_W = 8;
  localparam int PIX_OVL_W = 2;
  localparam int PIX_RGB_W = 24;

  // Overlay selector value n (n >= 1) maps to overlay slot n-1.
  function automatic logic [PIX_OVL_W-1:0] ovl_slot(input logic [PIX_OVL_W-1:0] sel);
    return sel - PIX_OVL_W'(1);
  endfunction

  // Priority: blank, then black, then overlay, then main palette.
  function automatic logic [PIX_RGB_W-1:0] pick_rgb(
    input logic                 blank_n,
    input logic                 cs_n,
    input logic [PIX_OVL_W-1:0] sel,
    input logic [PIX_RGB_W-1:0] ovl_rgb,
    input logic [PIX_RGB_W-1:0] main_rgb
  );
    if (!blank_n || !cs_n) return '0;
    if (sel != '0)         return ovl_rgb;
    return main_rgb;
  endfunction
endpackage

// File: rtl/pal_in_stage.sv
module pal_in_stage #(
  parameter int IDX_W = 8,
  parameter int OVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic [OVL_W-1:0] ovl_sel,
  input  logic             blank_n,
  input  logic             sync_n,
  input  logic             cs_n,
  output logic [IDX_W-1:0] idx_q,
  output logic [OVL_W-1:0] ovl_q,
  output logic             blank_n_q,
  output logic             sync_n_q,
  output logic             cs_n_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      ovl_q     <= '0;
      blank_n_q <= 1'b0;
      sync_n_q  <= 1'b0;
      cs_n_q    <= 1'b1;
    end else begin
      idx_q     <= pix_idx;
      ovl_q     <= ovl_sel;
      blank_n_q <= blank_n;
      sync_n_q  <= sync_n;
      cs_n_q    <= cs_n;
    end
  end
endmodule

// File: rtl/pal_main_ram.sv
module pal_main_ram #(
  parameter int IDX_W = 8,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [RGB_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [RGB_W-1:0] rd_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [RGB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/pal_ovl_regs.sv
module pal_ovl_regs #(
  parameter int OVL_W = 2,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OVL_W-1:0] wr_sel,
  input  logic [RGB_W-1:0] wr_data,
  input  logic [OVL_W-1:0] rd_sel,
  output logic [RGB_W-1:0] rd_data
);
  localparam int DEPTH = (1 << OVL_W) - 1;

  logic [RGB_W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                 ent[g] <= '0;
      else if (wr_en && wr_sel == OVL_W'(g + 1))  ent[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel != '0) rd_data = ent[pal_pkg::ovl_slot(rd_sel)];
  end
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage #(
  parameter int OVL_W = 2,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_n_q,
  input  logic             sync_n_q,
  input  logic             cs_n_q,
  input  logic [OVL_W-1:0] ovl_q,
  input  logic [RGB_W-1:0] ovl_rgb,
  input  logic [RGB_W-1:0] main_rgb_q,
  output logic [RGB_W-1:0] out_rgb,
  output logic             out_blank,
  output logic             out_black,
  output logic             out_sync_en
);
  logic             blank_n_r, cs_n_r, sync_n_r;
  logic [OVL_W-1:0] ovl_r;
  logic [RGB_W-1:0] ovl_rgb_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_n_r <= 1'b0;
      cs_n_r    <= 1'b1;
      sync_n_r  <= 1'b0;
      ovl_r     <= '0;
      ovl_rgb_r <= '0;
    end else begin
      blank_n_r <= blank_n_q;
      cs_n_r    <= cs_n_q;
      sync_n_r  <= sync_n_q;
      ovl_r     <= ovl_q;
      ovl_rgb_r <= ovl_rgb;
    end
  end

  assign out_blank   = !blank_n_r;
  assign out_black   = blank_n_r && !cs_n_r;
  assign out_sync_en = sync_n_r;
  assign out_rgb     = pal_pkg::pick_rgb(blank_n_r, cs_n_r, ovl_r, ovl_rgb_r, main_rgb_q);
endmodule

// File: rtl/pal_pixel_pipe.sv
module pal_pixel_pipe #(
  parameter int IDX_W = pal_pkg::PIX_IDX_W,
  parameter int OVL_W = pal_pkg::PIX_OVL_W,
  parameter int RGB_W = pal_pkg::PIX_RGB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic [OVL_W-1:0] ovl_sel,
  input  logic             blank_n,
  input  logic             sync_n,
  input  logic             cs_n,
  input  logic             wr_en,
  input  logic             wr_to_ovl,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [RGB_W-1:0] wr_data,
  output logic [RGB_W-1:0] out_rgb,
  output logic             out_blank,
  output logic             out_black,
  output logic             out_sync_en
);
  logic [IDX_W-1:0] idx_q;
  logic [OVL_W-1:0] ovl_q;
  logic             blank_n_q, sync_n_q, cs_n_q;
  logic [RGB_W-1:0] main_rgb_q, ovl_rgb;
  logic             wr_main, wr_ovl;

  assign wr_main = wr_en && !wr_to_ovl;
  assign wr_ovl  = wr_en && wr_to_ovl;

  pal_in_stage #(.IDX_W(IDX_W), .OVL_W(OVL_W)) u_in (
    .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .ovl_sel(ovl_sel),
    .blank_n(blank_n), .sync_n(sync_n), .cs_n(cs_n),
    .idx_q(idx_q), .ovl_q(ovl_q), .blank_n_q(blank_n_q),
    .sync_n_q(sync_n_q), .cs_n_q(cs_n_q)
  );

  pal_main_ram #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_main), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(idx_q), .rd_q(main_rgb_q)
  );

  pal_ovl_regs #(.OVL_W(OVL_W), .RGB_W(RGB_W)) u_ovl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ovl), .wr_sel(wr_addr[OVL_W-1:0]),
    .wr_data(wr_data), .rd_sel(ovl_q), .rd_data(ovl_rgb)
  );

  pal_out_stage #(.OVL_W(OVL_W), .RGB_W(RGB_W)) u_out (
    .clk(clk), .rst_n(rst_n), .blank_n_q(blank_n_q), .sync_n_q(sync_n_q),
    .cs_n_q(cs_n_q), .ovl_q(ovl_q), .ovl_rgb(ovl_rgb), .main_rgb_q(main_rgb_q),
    .out_rgb(out_rgb), .out_blank(out_blank), .out_black(out_black),
    .out_sync_en(out_sync_en)
  );

  // Cycles since reset, saturating at 2, so two-deep history is valid.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end
  logic primed;
  assign primed = (since_rst == 2'd2);

  assert_blank_pipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(blank_n, 2)) |-> (out_blank && out_rgb == '0));

  assert_black_pipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(blank_n, 2) && !$past(cs_n, 2)) |-> (out_black && !out_blank && out_rgb == '0));

  assert_sync_pipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (out_sync_en == $past(sync_n, 2)));

  assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_blank && out_black));

  assert_reset_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (out_blank && !out_black && !out_sync_en && out_rgb == '0));
endmodule

// File: tb/pal_pixel_pipe_tb.sv
module pal_pixel_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pix_idx;
  logic [1:0]  ovl_sel;
  logic        blank_n, sync_n, cs_n;
  logic        wr_en, wr_to_ovl;
  logic [7:0]  wr_addr;
  logic [23:0] wr_data;
  logic [23:0] out_rgb;
  logic        out_blank, out_black, out_sync_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] main_m [256];
  logic [23:0] ovl_m  [3];

  always #5 clk = ~clk;

  pal_pixel_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .ovl_sel(ovl_sel),
    .blank_n(blank_n), .sync_n(sync_n), .cs_n(cs_n), .wr_en(wr_en),
    .wr_to_ovl(wr_to_ovl), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_rgb(out_rgb), .out_blank(out_blank), .out_black(out_black),
    .out_sync_en(out_sync_en)
  );

  function automatic logic [23:0] gen_rgb(input int i, input logic [7:0] salt);
    return {8'(i) ^ salt, ~8'(i), 8'(i * 7 + 3)};
  endfunction

  task automatic chk(input string req, input logic eb, input logic ek,
                     input logic es, input logic [23:0] er);
    n_chk++;
    if (out_blank !== eb || out_black !== ek || out_sync_en !== es || out_rgb !== er) begin
      n_bad++;
      $display("FAIL %s: got blank=%b black=%b sync=%b rgb=%h, expected blank=%b black=%b sync=%b rgb=%h",
               req, out_blank, out_black, out_sync_en, out_rgb, eb, ek, es, er);
    end
  endtask

  // Drive a pixel, wait two edges, sample at the following falling edge.
  task automatic show(input logic [7:0] idx, input logic [1:0] ov,
                      input logic bl, input logic sy, input logic cs);
    @(negedge clk);
    pix_idx = idx; ovl_sel = ov; blank_n = bl; sync_n = sy; cs_n = cs;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [23:0] exp_rgb(input logic [7:0] idx, input logic [1:0] ov,
                                          input logic bl, input logic cs);
    if (!bl || !cs) return 24'h0;
    if (ov != 2'd0) return ovl_m[ov - 2'd1];
    return main_m[idx];
  endfunction

  task automatic wr(input logic to_ovl, input logic [7:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_to_ovl = to_ovl; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    pix_idx = 8'hff; ovl_sel = 2'd2; blank_n = 1'b1; sync_n = 1'b1; cs_n = 1'b1;
    wr_en = 1'b0; wr_to_ovl = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", 1'b1, 1'b0, 1'b0, 24'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_load;
    for (int i = 0; i < 256; i++) begin
      main_m[i] = gen_rgb(i, 8'h5a);
      wr(1'b0, 8'(i), main_m[i]);
    end
    for (int i = 0; i < 3; i++) begin
      ovl_m[i] = 24'hc0ffe0 + 24'(i * 24'h010101);
      wr(1'b1, 8'(i + 1) | 8'hf0, ovl_m[i]);   // R9: upper address bits ignored
    end
  endtask

  task automatic t_main_R3_R8;
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      show(8'(i), 2'd0, 1'b1, 1'b1, 1'b1);
      if (out_rgb !== main_m[i]) bad++;
    end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL R3/R8 main palette sweep: %0d mismatching entries, expected 0", bad);
    end
    show(8'h01, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R3 idx bit0 LSB", 1'b0, 1'b0, 1'b1, main_m[1]);
    show(8'h80, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R3 idx bit7", 1'b0, 1'b0, 1'b1, main_m[128]);
  endtask

  task automatic t_overlay_R4;
    for (int s = 1; s < 4; s++) begin
      show(8'h00, 2'(s), 1'b1, 1'b1, 1'b1);
      chk("R4 overlay idx0", 1'b0, 1'b0, 1'b1, ovl_m[s - 1]);
      show(8'hc3, 2'(s), 1'b1, 1'b1, 1'b1);
      chk("R4 overlay idx ignored", 1'b0, 1'b0, 1'b1, ovl_m[s - 1]);
    end
  endtask

  task automatic t_ovl_ignore_R9;
    wr(1'b1, 8'h00, 24'hdead00);
    wr(1'b1, 8'hfc, 24'hdead01);
    for (int s = 1; s < 4; s++) begin
      show(8'h10, 2'(s), 1'b1, 1'b1, 1'b1);
      chk("R9 overlay addr0 write ignored", 1'b0, 1'b0, 1'b1, ovl_m[s - 1]);
    end
    show(8'h00, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R9 overlay write leaves main", 1'b0, 1'b0, 1'b1, main_m[0]);
  endtask

  task automatic t_blank_R5;
    show(8'h33, 2'd0, 1'b0, 1'b1, 1'b1);
    chk("R5 blank main", 1'b1, 1'b0, 1'b1, 24'h0);
    show(8'h33, 2'd3, 1'b0, 1'b0, 1'b1);
    chk("R5 blank overlay", 1'b1, 1'b0, 1'b0, 24'h0);
    show(8'h33, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R5 blank over cs", 1'b1, 1'b0, 1'b1, 24'h0);
  endtask

  task automatic t_black_R6;
    show(8'h44, 2'd0, 1'b1, 1'b1, 1'b0);
    chk("R6 black main", 1'b0, 1'b1, 1'b1, 24'h0);
    show(8'h44, 2'd2, 1'b1, 1'b0, 1'b0);
    chk("R6 black overlay", 1'b0, 1'b1, 1'b0, 24'h0);
    show(8'h44, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R6 cs released", 1'b0, 1'b0, 1'b1, exp_rgb(8'h44, 2'd0, 1'b1, 1'b1));
  endtask

  task automatic t_sync_R7;
    show(8'h77, 2'd0, 1'b1, 1'b0, 1'b1);
    chk("R7 sync low keeps colour", 1'b0, 1'b0, 1'b0, main_m[8'h77]);
    show(8'h77, 2'd2, 1'b1, 1'b0, 1'b1);
    chk("R7 sync low overlay", 1'b0, 1'b0, 1'b0, ovl_m[1]);
    show(8'h77, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R7 sync high", 1'b0, 1'b0, 1'b1, main_m[8'h77]);
  endtask

  task automatic t_latency_R2;
    show(8'h20, 2'd0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    pix_idx = 8'h21; ovl_sel = 2'd0; blank_n = 1'b1; sync_n = 1'b1; cs_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 not yet after one edge", 1'b1, 1'b0, 1'b0, 24'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 visible after two edges", 1'b0, 1'b0, 1'b1, main_m[8'h21]);
  endtask

  task automatic t_write_again_R8;
    main_m[8'h55] = 24'h123456;
    wr(1'b0, 8'h55, main_m[8'h55]);
    show(8'h55, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R8 rewrite main entry", 1'b0, 1'b0, 1'b1, 24'h123456);
    show(8'h56, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R8 neighbour untouched", 1'b0, 1'b0, 1'b1, main_m[8'h56]);
  endtask

  initial begin
    t_reset;
    t_load;
    t_main_R3_R8;
    t_overlay_R4;
    t_ovl_ignore_R9;
    t_blank_R5;
    t_black_R6;
    t_sync_R7;
    t_latency_R2;
    t_write_again_R8;
    // R10: the exclusivity of blank and black is covered by every chk above.
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule